// File: doc/BRIEF.md
# Protected Clock Prescaler Register

This block divides a master clock by a selectable power of two, from 1 to 256, and emits a clock-enable pulse. The pulse is one master cycle wide. Synchronous logic downstream qualifies its registers with this pulse, so it runs at the reduced rate. The factor is held in a 4-bit select field of an 8-bit register. Software reaches that register over a simple I/O bus with an address, write data, a write strobe and combinational read data.

An unlock sequence guards the select field against accidental changes. Software first writes a signature byte to a separate protection address. That opens a window of four master cycles, and within it one write to the select field is accepted. A write to the select field at any other time is dropped. The divide counter adopts a new factor only when it wraps, so the pulse spacing never breaks the old or the new period.

Top module: `prot_clk_prescaler`

## Requirements
- R1: After reset the select field reads back as 8'h03 and `clk_en` pulses once every 8 master cycles.
- R2: Bits 7:4 of the prescaler register always read as zero, and written values in those bits have no effect. Reading any address other than the prescaler address returns zero.
- R3: With a select code k in 0..8 in force, `clk_en` is high for exactly one master cycle every 2^k master cycles. For k=0 it is high on every cycle.
- R4: A write to the prescaler address is accepted only if the signature was written to the protection address 1 to 4 cycles earlier. A write 5 or more cycles after the signature is discarded.
- R5: A write to the prescaler address with no preceding signature leaves the register unchanged.
- R6: Writing any value other than the signature to the protection address closes an open window at once.
- R7: An accepted prescaler write consumes the unlock, so a second write needs a new signature.
- R8: Reserved codes 9..15 written inside the window are stored and read back. The divider keeps the last valid factor.
- R9: A new factor takes effect only when the divide counter wraps. The interval that is running when the write lands keeps the old length, and the following intervals use the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | I/O bus address |
| bus_wdata | input | 8 | I/O bus write data |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| clk_en | output | 1 | One-cycle clock-enable pulse at the divided rate |

## Verification
The embedded properties check several things on every cycle:
- the select field changes only in a cycle that follows a write inside an open window;
- the window opens only after a signature write and closes after a consuming write or after a wrong byte;
- the window count never exceeds its limit;
- the divide counter stays within the active period;
- a reserved code never reaches the active factor;
- the enable stays one cycle wide whenever the next factor is above one.

Other properties need whole scenarios, which the bench supplies:
- the exact spacing for every ratio;
- the boundary between a write on the fourth cycle and one on the fifth;
- a new factor waiting for the wrap;
- the reset value restored in the middle of operation.

// File: rtl/clkpre_pkg.sv
// Package: constants shared by the protected prescaler blocks.
// Assumes an 8-bit I/O data path and a 4-bit select field in its low bits.
package clkpre_pkg;
    localparam int DATA_W     = 8;
    localparam int SEL_W      = 4;
    localparam int MAX_CODE   = 8;                 // highest valid select code (divide by 256)
    localparam int DIV_CNT_W  = MAX_CODE;          // counter wide enough for 2^MAX_CODE - 1
    localparam logic [SEL_W-1:0] RESET_CODE = 4'd3; // divide by 8 after reset
endpackage

// File: rtl/unlock_guard.sv
// Module: unlock_guard
// Opens a write window of WINDOW master cycles when the signature byte is
// written to the protection address. A wrong byte closes the window, and so
// does a write to the prescaler that consumes it.
// Assumes at most one bus write per cycle.
module unlock_guard #(
    parameter int          WINDOW    = 4,
    parameter logic [7:0]  SIGNATURE = 8'hD8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prot_wr,
    input  logic [7:0] wdata,
    input  logic       consume,
    output logic       win_open
);
    localparam int CNT_W = $clog2(WINDOW + 1);
    localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WINDOW);

    logic [CNT_W-1:0] win_cnt;
    logic             sig_ok;

    assign sig_ok   = (wdata == SIGNATURE);
    assign win_open = (win_cnt != '0);

    // Purpose: load, clear or count down the remaining window cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (prot_wr) begin
            win_cnt <= sig_ok ? WIN_LOAD : '0;
        end else if (consume) begin
            win_cnt <= '0;
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    // R4
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_LOAD);
    // R4
    win_open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(prot_wr && sig_ok));
    // R6
    bad_sig_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !sig_ok) |=> !win_open);
    // R7
    consume_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !prot_wr) |=> !win_open);
endmodule

// File: rtl/presc_sel_reg.sv
// Module: presc_sel_reg
// Holds the 4-bit select field and the last valid code that the divider uses.
// Writes land only while the unlock window is open. Reserved codes are stored
// for readback but never forwarded to the divider.
module presc_sel_reg
    import clkpre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] wdata,
    input  logic             win_open,
    output logic             accepted,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] valid_q
);
    logic code_valid;

    assign accepted   = sel_wr && win_open;
    assign code_valid = (wdata <= SEL_W'(MAX_CODE));

    // Purpose: capture an unlocked write; update the valid factor only for legal codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= RESET_CODE;
            valid_q <= RESET_CODE;
        end else if (accepted) begin
            sel_q <= wdata;
            if (code_valid) begin
                valid_q <= wdata;
            end
        end
    end

    // R4
    sel_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> $past(sel_wr && win_open));
    // R8
    valid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q <= SEL_W'(MAX_CODE));
    // R8
    reserved_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && win_open && (wdata > SEL_W'(MAX_CODE))) |=> $stable(valid_q));
endmodule

// File: rtl/pow2_divider.sv
// Module: pow2_divider
// Free-running counter that emits a one-cycle enable every 2^k cycles.
// The requested code k is sampled only at the wrap, so every interval is a
// whole old period or a whole new period. Assumes code_req <= MAX_CODE.
module pow2_divider
    import clkpre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] code_req,
    output logic             tick
);
    logic [DIV_CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0]     active_q;
    logic [DIV_CNT_W-1:0] lim;

    // Purpose: terminal count for the active factor, 2^k - 1.
    always_comb begin
        lim = ~({DIV_CNT_W{1'b1}} << active_q);
    end

    assign tick = (cnt_q == lim);

    // Purpose: count up, wrap at the limit and adopt the requested factor on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            active_q <= RESET_CODE;
        end else if (tick) begin
            cnt_q    <= '0;
            active_q <= code_req;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
    // R9
    switch_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> $past(tick));
    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (code_req != '0)) |=> !tick);
    // R8
    active_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q <= SEL_W'(MAX_CODE));
endmodule

// File: rtl/prot_clk_prescaler.sv
// Module: prot_clk_prescaler (top)
// Bus-mapped prescaler register with change protection. The top decodes the
// two addresses, builds read data and drives the clock-enable output.
// Assumes the bus presents one access per cycle and reads are combinational.
module prot_clk_prescaler
    import clkpre_pkg::*;
#(
    parameter int                ADDR_W     = 6,
    parameter logic [ADDR_W-1:0] PRESC_ADDR = 6'h36,
    parameter logic [ADDR_W-1:0] PROT_ADDR  = 6'h3C,
    parameter logic [7:0]        SIGNATURE  = 8'hD8,
    parameter int                WINDOW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              clk_en
);
    localparam int PAD_W = DATA_W - SEL_W;

    logic             prot_wr;
    logic             sel_wr;
    logic             win_open;
    logic             accepted;
    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] valid_q;

    assign prot_wr = bus_wr && (bus_addr == PROT_ADDR);
    assign sel_wr  = bus_wr && (bus_addr == PRESC_ADDR);

    unlock_guard #(
        .WINDOW    (WINDOW),
        .SIGNATURE (SIGNATURE)
    ) guard_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_wr  (prot_wr),
        .wdata    (bus_wdata),
        .consume  (accepted),
        .win_open (win_open)
    );

    presc_sel_reg sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (sel_wr),
        .wdata    (bus_wdata[SEL_W-1:0]),
        .win_open (win_open),
        .accepted (accepted),
        .sel_q    (sel_q),
        .valid_q  (valid_q)
    );

    pow2_divider div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_req (valid_q),
        .tick     (clk_en)
    );

    // Purpose: read mux; upper field bits and unmapped addresses read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == PRESC_ADDR) begin
            bus_rdata = {{PAD_W{1'b0}}, sel_q};
        end
    end

    // R2
    rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:SEL_W] == '0);
endmodule

// File: tb/prot_clk_prescaler_tb_top.sv
module prot_clk_prescaler_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_PRESC = 6'h36;
    localparam logic [5:0] A_PROT  = 6'h3C;
    localparam logic [7:0] SIG     = 8'hD8;
    localparam int VEC_N = 9;
    localparam logic [7:0] VEC_DATA [VEC_N] =
        '{8'hA0, 8'h01, 8'hF2, 8'h03, 8'h04, 8'h55, 8'h06, 8'h07, 8'h38};
    localparam int VEC_PER [VEC_N] = '{1, 2, 4, 8, 16, 32, 64, 128, 256};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic       clk_en;
    int checks = 0;
    int fails  = 0;

    prot_clk_prescaler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .clk_en    (clk_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write is captured at the next posedge
    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int exp);
        bus_addr = A_PRESC; bus_wr = 1'b0;
        #1;
        chk(req, int'(bus_rdata), exp);
    endtask

    task automatic measure(output int p);
        while (!clk_en) @(negedge clk);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!clk_en);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int p;
        int prev_sel;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value and reset period
        rd_chk("R1 reset readback", 8'h03);
        measure(p); measure(p);
        chk("R1 reset period", p, 8);

        // R3 / R2: every valid ratio through the table
        for (int i = 0; i < VEC_N; i++) begin
            bus_write(A_PROT, SIG);
            bus_write(A_PRESC, VEC_DATA[i]);
            rd_chk("R2 upper bits read zero", int'(VEC_DATA[i] & 8'h0F));
            measure(p); measure(p);
            chk("R3 divide period", p, VEC_PER[i]);
        end

        // R9: now at divide-256; change lands at the wrap
        measure(p);
        bus_write(A_PROT, SIG);
        bus_write(A_PRESC, 8'h01);
        p = 2;
        do begin @(negedge clk); p++; end while (!clk_en);
        chk("R9 old period kept until wrap", p, 256);
        measure(p);
        chk("R9 new period after wrap", p, 2);

        // R5: unprotected write ignored
        bus_write(A_PRESC, 8'h05);
        rd_chk("R5 unprotected write ignored", 8'h01);
        measure(p); measure(p);
        chk("R5 period unchanged", p, 2);

        // R4: write on the fifth cycle is discarded
        bus_write(A_PROT, SIG);
        idle(4);
        bus_write(A_PRESC, 8'h02);
        rd_chk("R4 late write discarded", 8'h01);

        // R4: write on the fourth cycle is accepted
        bus_write(A_PROT, SIG);
        idle(3);
        bus_write(A_PRESC, 8'h02);
        rd_chk("R4 fourth-cycle write accepted", 8'h02);

        // R7: second write without new signature is rejected
        bus_write(A_PRESC, 8'h04);
        rd_chk("R7 unlock consumed", 8'h02);

        // R6: wrong byte closes the window
        bus_write(A_PROT, SIG);
        bus_write(A_PROT, 8'hD9);
        bus_write(A_PRESC, 8'h06);
        rd_chk("R6 wrong signature closes window", 8'h02);

        // R2: read of the protection address returns zero
        bus_addr = A_PROT; #1;
        chk("R2 other address reads zero", int'(bus_rdata), 0);

        // R8: reserved code stored, divider keeps divide-by-4
        bus_write(A_PROT, SIG);
        bus_write(A_PRESC, 8'h0B);
        rd_chk("R8 reserved code read back", 8'h0B);
        measure(p); measure(p);
        chk("R8 divider keeps last valid", p, 4);
        prev_sel = 8'h0B;
        bus_write(A_PROT, SIG);
        bus_write(A_PRESC, 8'h0F);
        rd_chk("R8 code 15 read back", 8'h0F);
        measure(p); measure(p);
        chk("R8 still last valid after 15", p, 4);

        // R1: reset in mid-run restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        rd_chk("R1 readback after reset", 8'h03);
        measure(p); measure(p);
        chk("R1 period after reset", p, 8);
        if (prev_sel == 0) $display("unused");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule